// File: doc/BRIEF.md
# Two-Digit Decimal Countdown Timer

This block is a two-digit decimal timer with an alarm. The user loads a value from 00 to 99 one digit at a time, using a start/stop button and one set button per digit. The timer then counts down once per tick until it reaches zero, where it raises an alarm. Each digit is held in BCD. A digit can step up or down, wrapping from 9 to 0 going up and from 0 to 9 going down. Combinational flags mark a digit value of zero and of nine.

A five-state controller sequences the timer: idle, setting the upper digit, setting the lower digit, running, and stopped. The tick comes from an internal prescaler that divides the clock by `TICK_DIV` while the timer runs. The block detects rising edges on its three button inputs, so a held button acts as a single press. The start/stop button pauses and resumes a running count. After the alarm, the same button clears the alarm and returns the block to idle. Debouncing and display decoding belong outside the block.

Top module: `bcd_countdown_timer`

## Requirements
- R1: A synchronous active-high `rst` puts the controller in idle, clears both digits to 0 and drives `alarm_o` low.
- R2: In idle, set presses leave both digits unchanged. A start/stop press moves to upper-digit setting.
- R3: While setting the upper digit, each upper-set press adds one to the upper digit, with 9 wrapping to 0. Lower-set presses are ignored.
- R4: While setting the lower digit, each lower-set press adds one to the lower digit, with 9 wrapping to 0. Upper-set presses are ignored. A start/stop press starts the run.
- R5: While running, the lower digit drops by one every `TICK_DIV` cycles. The first drop occurs `TICK_DIV` clock edges after the edge that entered the run. A lower digit at 0 wraps to 9 and borrows one from the upper digit in the same edge, so 10 becomes 09.
- R6: A start/stop press while running pauses the count with the alarm low. Another press resumes it with a full tick period before the next drop.
- R7: When counting reaches 00, the alarm rises on the next clock edge and stays high. The digits stay at 00 and do not wrap to 99.
- R8: With the alarm high, a start/stop press clears the alarm and returns to idle. The digits keep their value.
- R9: A run started at 00 stops at once and never raises the alarm.
- R10: Each input acts on its rising edge only. Holding an input high for several cycles counts as one press.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_stop_i | input | 1 | Start/stop button level |
| set_hi_i | input | 1 | Upper-digit set button level |
| set_lo_i | input | 1 | Lower-digit set button level |
| digit_hi_o | output | 4 | Upper BCD digit |
| digit_lo_o | output | 4 | Lower BCD digit |
| alarm_o | output | 1 | High once the countdown has reached 00 |

## Verification
The bench targets four failure points:
- **Borrow from 30 to 29 and from 10 to 09:** a design that drops the borrow or mistimes it shows 20 or 19.
- **Arrival at 00:** a design without a zero guard wraps to 99, and one that mistimes the alarm raises it on the wrong cycle.
- **Set wrap and wrong-digit presses:** wrap from 9 to 0 under set presses is checked, and set presses aimed at the wrong digit or held for several cycles must not be counted.
- **Start at 00:** a design that raises the alarm merely on reaching zero gives a false alarm here. Pause and resume are timed so that a prescaler that does not restart is caught.

// File: rtl/bcd_countdown_timer.sv
module bcd_countdown_timer #(
  parameter int TICK_DIV = 1000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_stop_i,
  input  logic       set_hi_i,
  input  logic       set_lo_i,
  output logic [3:0] digit_hi_o,
  output logic [3:0] digit_lo_o,
  output logic       alarm_o
);
  localparam int PW = $clog2(TICK_DIV + 1);
  localparam logic [PW-1:0] PRE_LAST = PW'(TICK_DIV - 1);

  typedef enum logic [2:0] {S_IDLE, S_SETHI, S_SETLO, S_RUN, S_STOP} state_t;

  state_t        state;
  logic [2:0]    btn_q;
  logic [PW-1:0] pre;
  logic [3:0]    hi, lo;
  logic          alarm, counted;

  wire ss_p = start_stop_i & ~btn_q[0];
  wire sh_p = set_hi_i     & ~btn_q[1];
  wire sl_p = set_lo_i     & ~btn_q[2];

  wire hi_z = (hi == 4'd0);
  wire hi_n = (hi == 4'd9);
  wire lo_z = (lo == 4'd0);
  wire lo_n = (lo == 4'd9);
  wire both_z = hi_z & lo_z;

  wire tick     = (state == S_RUN) && (pre == PRE_LAST);
  wire count_en = tick & ~both_z & ~ss_p;
  wire up_hi    = (state == S_SETHI) & sh_p;
  wire up_lo    = (state == S_SETLO) & sl_p;
  wire dn_lo    = count_en;
  wire dn_hi    = count_en & lo_z;

  function automatic logic [3:0] bcd_step(input logic [3:0] v, input logic up,
                                           input logic dn, input logic z, input logic n);
    logic [4:0] c, b;
    logic [3:0] inc, dec;
    c[0] = 1'b1;
    b[0] = 1'b1;
    for (int i = 0; i < 4; i++) begin
      inc[i]   = v[i] ^ c[i];
      c[i+1]   = c[i] & v[i];
      dec[i]   = v[i] ^ b[i];
      b[i+1]   = b[i] & ~v[i];
    end
    if (up && !dn)      return n ? 4'd0 : inc;
    else if (dn && !up) return z ? 4'd9 : dec;
    else                return v;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) btn_q <= '0;
    else     btn_q <= {set_lo_i, set_hi_i, start_stop_i};
  end

  always_ff @(posedge clk) begin
    if (rst || state != S_RUN || pre == PRE_LAST) pre <= '0;
    else                                        pre <= pre + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi <= 4'd0;
      lo <= 4'd0;
    end else begin
      hi <= bcd_step(hi, up_hi, dn_hi, hi_z, hi_n);
      lo <= bcd_step(lo, up_lo, dn_lo, lo_z, lo_n);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      alarm   <= 1'b0;
      counted <= 1'b0;
    end else begin
      case (state)
        S_IDLE:  if (ss_p) state <= S_SETHI;
        S_SETHI: if (ss_p) state <= S_SETLO;
        S_SETLO: if (ss_p) begin
          state   <= S_RUN;
          counted <= 1'b0;
        end
        S_RUN: begin
          if (count_en) counted <= 1'b1;
          if (both_z) begin
            state <= S_STOP;
            alarm <= counted;
          end else if (ss_p) begin
            state <= S_STOP;
          end
        end
        S_STOP: if (ss_p) begin
          if (alarm) begin
            state <= S_IDLE;
            alarm <= 1'b0;
          end else begin
            state <= S_RUN;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign digit_hi_o = hi;
  assign digit_lo_o = lo;
  assign alarm_o    = alarm;

  // R3 R4 R5
  digits_bcd_chk: assert property (@(posedge clk) disable iff (rst)
    (hi <= 4'd9) && (lo <= 4'd9));

  // R7
  alarm_only_stop_chk: assert property (@(posedge clk) disable iff (rst)
    alarm |-> (state == S_STOP));

  // R7
  alarm_from_run_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(alarm) |-> ($past(state) == S_RUN));

  // R7 R9
  run_zero_stops_chk: assert property (@(posedge clk) disable iff (rst)
    ((state == S_RUN) && both_z) |=> (state == S_STOP));

  // R2 R6 R8
  hold_digits_chk: assert property (@(posedge clk) disable iff (rst)
    ((state == S_IDLE) || (state == S_STOP)) |=> $stable({hi, lo}));

  // R5
  borrow_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (count_en && lo_z) |=> (lo == 4'd9) && (hi == $past(hi) - 4'd1));
endmodule

// File: tb/test_bcd_countdown_timer.sv
module test_bcd_countdown_timer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ss = 1'b0, sh = 1'b0, sl = 1'b0;
  logic [3:0] dhi, dlo;
  logic alarm;

  int vectors = 0;
  int miss = 0;
  bit done = 1'b0;

  typedef struct {
    logic [3:0] hi;
    logic [3:0] lo;
    logic       al;
    string      req;
  } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  bcd_countdown_timer #(.TICK_DIV(4)) i_bcd_countdown_timer (
    .clk(clk), .rst(rst), .start_stop_i(ss), .set_hi_i(sh), .set_lo_i(sl),
    .digit_hi_o(dhi), .digit_lo_o(dlo), .alarm_o(alarm));

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic press(input int sel);
    if (sel == 0) ss = 1'b1; else if (sel == 1) sh = 1'b1; else sl = 1'b1;
    step(1);
    ss = 1'b0; sh = 1'b0; sl = 1'b0;
    step(1);
  endtask

  task automatic expect_out(input logic [3:0] h, input logic [3:0] l,
                            input logic a, input string r);
    exp_t e;
    e.hi = h; e.lo = l; e.al = a; e.req = r;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      vectors++;
      if (dhi !== e.hi || dlo !== e.lo || alarm !== e.al) begin
        miss++;
        $display("FAIL %s: got %0d%0d alarm=%0b, expected %0d%0d alarm=%0b",
                 e.req, dhi, dlo, alarm, e.hi, e.lo, e.al);
      end
    end
  end

  initial begin
    step(3);
    expect_out(0, 0, 0, "R1");
    rst = 1'b0;
    step(1);
    press(1); press(2);
    expect_out(0, 0, 0, "R2");
    press(0);
    press(1); press(1);
    sh = 1'b1; step(5); sh = 1'b0; step(1);
    expect_out(3, 0, 0, "R10");
    press(2);
    expect_out(3, 0, 0, "R3");
    press(0);
    for (int i = 0; i < 9; i++) press(2);
    expect_out(3, 9, 0, "R4");
    press(2);
    expect_out(3, 0, 0, "R4");
    press(2); press(2); press(1);
    expect_out(3, 2, 0, "R4");
    press(0);
    expect_out(3, 2, 0, "R5");
    step(3);
    expect_out(3, 1, 0, "R5");
    step(4);
    expect_out(3, 0, 0, "R5");
    step(4);
    expect_out(2, 9, 0, "R5");
    press(0);
    expect_out(2, 9, 0, "R6");
    step(20);
    expect_out(2, 9, 0, "R6");
    press(0);
    step(111);
    expect_out(0, 1, 0, "R6");
    step(4);
    expect_out(0, 0, 0, "R7");
    step(1);
    expect_out(0, 0, 1, "R7");
    step(10);
    expect_out(0, 0, 1, "R7");
    press(0);
    expect_out(0, 0, 0, "R8");
    press(1);
    expect_out(0, 0, 0, "R2");
    press(0); press(0); press(0);
    expect_out(0, 0, 0, "R9");
    step(20);
    expect_out(0, 0, 0, "R9");
    rst = 1'b1; step(2); rst = 1'b0; step(1);
    press(0);
    for (int i = 0; i < 9; i++) press(1);
    expect_out(9, 0, 0, "R3");
    press(1);
    expect_out(0, 0, 0, "R3");
    press(1);
    press(0);
    press(1);
    expect_out(1, 0, 0, "R4");
    press(0);
    step(3);
    expect_out(0, 9, 0, "R5");
    step(36);
    expect_out(0, 0, 0, "R7");
    step(1);
    expect_out(0, 0, 1, "R7");
    step(2);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      miss++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
      $finish;
    end
  end
endmodule